// File: doc/BRIEF.md
# Program Exception Dispatch Classifier

This block sits at the completion stage of a small RISC core. For each instruction it accepts, it looks at the decoded instruction flags, the privilege level, the two floating-point enable bits from the machine state, and the floating-point exception flags, enables and sticky bits. It then chooses one of three ways to finish the instruction. The instruction completes normally, it raises a program exception at vector 0x00700, or it goes to the emulation trap at vector 0x01600. One cycle after the choice, the block presents a registered vector, a one-hot cause code, an exception flag, and write enables for the floating-point status register and the target floating-point register.

When several conditions hold at once, the block applies a fixed order of precedence. The two imprecise-mode combinations of the enable bits are folded into precise handling. A floating-point operation whose disabled exceptions set a sticky bit that was clear, with both enable bits clear, is serialized. For that case `busy` rises for exactly two cycles, and the result appears once it falls. An operation that raises only exceptions whose sticky bits are already set does not stall.

Top module: `prog_exc_classifier`

## Requirements
- R1: An instruction flagged illegal raises a program exception at vector 0x00700 with cause bit 0 set. Both write enables are low. This outcome takes precedence over every other condition.
- R2: A supervisor-only instruction in user mode (`user_mode`=1) raises a program exception at 0x00700 with cause bit 1 set. The same instruction in supervisor mode completes normally.
- R3: An instruction of a software-emulated class goes to vector 0x01600 with an all-zero cause and no writes. This outcome beats enabled floating-point exceptions and traps.
- R4: Suppose a floating-point instruction raises a flag whose enable bit is set. It goes to 0x01600 with cause bit 3 set and with both write enables low, whatever the values of `fe0` and `fe1`.
- R5: When `fe0` and `fe1` differ, the block treats them as both set. A disabled exception that newly sets a sticky bit therefore causes no stall.
- R6: Consider a floating-point instruction with both enable bits clear and no enabled flag raised, which raises a flag whose sticky bit is clear. It holds `busy` high for exactly 2 cycles and then completes normally with both write enables high.
- R7: A floating-point instruction completes without a stall when every flag it raises is already sticky, or when it raises no flag.
- R8: A trap instruction whose condition is met raises a program exception at 0x00700 with cause bit 2 set. When the condition is not met, the trap completes normally.
- R9: A completion without a stall is reported by a one-cycle `done_valid` pulse on the cycle after acceptance. A normal completion carries vector 0, cause 0 and `exc_taken`=0, and both write enables equal `is_fp`.
- R10: While `busy` is high, `cmpl_valid` is ignored. No extra completion is produced for it.
- R11: During and after reset, `done_valid`, `busy`, `exc_taken`, `vector`, `cause` and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_valid | input | 1 | An instruction is presented for completion |
| is_illegal | input | 1 | Decoder marks the opcode illegal for this implementation |
| is_supv | input | 1 | Instruction requires supervisor privilege |
| is_emul | input | 1 | Instruction class is handled in software |
| is_fp | input | 1 | Floating-point arithmetic instruction |
| is_trap | input | 1 | Trap instruction |
| user_mode | input | 1 | Core runs at user privilege |
| trap_hit | input | 1 | A trap condition of the instruction is met |
| fe0 | input | 1 | Machine-state floating-point enable bit 0 |
| fe1 | input | 1 | Machine-state floating-point enable bit 1 |
| fp_flags | input | NFLAG | Exceptions raised by this instruction |
| fp_enable | input | NFLAG | Exception enables in the status register |
| fp_sticky | input | NFLAG | Current sticky bits in the status register |
| busy | output | 1 | Completion held by serialization |
| done_valid | output | 1 | Completion result valid (one-cycle pulse) |
| exc_taken | output | 1 | Completion redirects to a vector |
| vector | output | VEC_W | Redirect vector, 0 when there is none |
| cause | output | 4 | One-hot cause: bit0 illegal, bit1 privileged, bit2 trap, bit3 floating-point |
| fpscr_we | output | 1 | Floating-point status register update allowed |
| fpr_we | output | 1 | Target floating-point register write allowed |

## Verification
A wrong precedence decision shows on the next cycle as the wrong vector or cause bit on the same `done_valid` pulse. A leaked write enable on a redirected instruction shows in that same cycle. A bad serialization counter shows as a `busy` run of the wrong length, or as a `done_valid` that comes early, late or twice. These errors are all visible within three cycles of acceptance. A stale latched result during a stall shows as wrong outputs on the delayed pulse.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

  localparam int CAUSE_W   = 4;
  localparam int C_ILLEGAL = 0;
  localparam int C_PRIV    = 1;
  localparam int C_TRAP    = 2;
  localparam int C_FP      = 3;

  typedef enum logic [2:0] {
    OUT_NORMAL  = 3'd0,
    OUT_ILLEGAL = 3'd1,
    OUT_PRIV    = 3'd2,
    OUT_EMUL    = 3'd3,
    OUT_FPEN    = 3'd4,
    OUT_TRAP    = 3'd5
  } outcome_e;

  // precedence: illegal, privileged, emulated class, enabled fp, trap
  function automatic outcome_e pick_outcome(
    input logic ill, input logic supv_user, input logic emul,
    input logic fp_trap, input logic trap_fire);
    if (ill)            return OUT_ILLEGAL;
    else if (supv_user) return OUT_PRIV;
    else if (emul)      return OUT_EMUL;
    else if (fp_trap)   return OUT_FPEN;
    else if (trap_fire) return OUT_TRAP;
    else                return OUT_NORMAL;
  endfunction

  function automatic logic [CAUSE_W-1:0] cause_of(input outcome_e o);
    logic [CAUSE_W-1:0] c;
    c = '0;
    case (o)
      OUT_ILLEGAL: c[C_ILLEGAL] = 1'b1;
      OUT_PRIV:    c[C_PRIV]    = 1'b1;
      OUT_TRAP:    c[C_TRAP]    = 1'b1;
      OUT_FPEN:    c[C_FP]      = 1'b1;
      default:     c = '0;
    endcase
    return c;
  endfunction

  function automatic logic uses_emu_vec(input outcome_e o);
    return (o == OUT_EMUL) || (o == OUT_FPEN);
  endfunction

  function automatic logic uses_prog_vec(input outcome_e o);
    return (o == OUT_ILLEGAL) || (o == OUT_PRIV) || (o == OUT_TRAP);
  endfunction

endpackage

// File: rtl/pexc_fe_fold.sv
module pexc_fe_fold (
  input  logic fe0,
  input  logic fe1,
  output logic eff_fe0,
  output logic eff_fe1,
  output logic fe_off
);
  // imprecise combinations (bits differ) run as fully precise
  logic mixed;
  assign mixed   = fe0 ^ fe1;
  assign eff_fe0 = fe0 | mixed;
  assign eff_fe1 = fe1 | mixed;
  assign fe_off  = ~eff_fe0 & ~eff_fe1;

  always_comb begin
    a_r5_fold_equal: assert (eff_fe0 == eff_fe1);
  end
endmodule

// File: rtl/pexc_decide.sv
module pexc_decide
  import pexc_pkg::*;
#(
  parameter int NFLAG = 5
) (
  input  logic             is_illegal,
  input  logic             is_supv,
  input  logic             is_emul,
  input  logic             is_fp,
  input  logic             is_trap,
  input  logic             user_mode,
  input  logic             trap_hit,
  input  logic             fe_off,
  input  logic [NFLAG-1:0] fp_flags,
  input  logic [NFLAG-1:0] fp_enable,
  input  logic [NFLAG-1:0] fp_sticky,
  output outcome_e         outcome,
  output logic             need_stall
);
  logic fp_en_hit;
  logic new_sticky;

  assign fp_en_hit  = is_fp & (|(fp_flags & fp_enable));
  assign new_sticky = |(fp_flags & ~fp_sticky);

  assign outcome = pick_outcome(is_illegal, is_supv & user_mode, is_emul,
                                fp_en_hit, is_trap & trap_hit);

  assign need_stall = (outcome == OUT_NORMAL) & is_fp & fe_off & new_sticky;

  always_comb begin
    if (is_illegal) a_r1_illegal_first: assert (outcome == OUT_ILLEGAL);
    if (need_stall) a_r6_stall_only_normal_fp: assert (is_fp && fe_off);
  end
endmodule

// File: rtl/pexc_serialize.sv
module pexc_serialize #(
  parameter int STALL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic need_stall,
  output logic busy,
  output logic release_now
);
  localparam int CW = $clog2(STALL_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (accept && need_stall) cnt <= CW'(STALL_CYC);
    else if (cnt != '0)           cnt <= cnt - 1'b1;
  end

  assign busy        = (cnt != '0);
  assign release_now = (cnt == CW'(1));

  // run-length checker for the busy window
  logic [7:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 8'd1;
    else           run_len <= '0;
  end

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 8'(STALL_CYC));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !release_now |=> busy);
endmodule

// File: rtl/prog_exc_classifier.sv
module prog_exc_classifier
  import pexc_pkg::*;
#(
  parameter int               NFLAG     = 5,
  parameter int               VEC_W     = 32,
  parameter logic [VEC_W-1:0] PROG_VEC  = 32'h0000_0700,
  parameter logic [VEC_W-1:0] EMU_VEC   = 32'h0000_1600,
  parameter int               STALL_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmpl_valid,
  input  logic               is_illegal,
  input  logic               is_supv,
  input  logic               is_emul,
  input  logic               is_fp,
  input  logic               is_trap,
  input  logic               user_mode,
  input  logic               trap_hit,
  input  logic               fe0,
  input  logic               fe1,
  input  logic [NFLAG-1:0]   fp_flags,
  input  logic [NFLAG-1:0]   fp_enable,
  input  logic [NFLAG-1:0]   fp_sticky,
  output logic               busy,
  output logic               done_valid,
  output logic               exc_taken,
  output logic [VEC_W-1:0]   vector,
  output logic [CAUSE_W-1:0] cause,
  output logic               fpscr_we,
  output logic               fpr_we
);

  // named internal events
  logic     eff_fe0, eff_fe1, fe_off;
  outcome_e dec_outcome;
  logic     need_stall;
  logic     accept;
  logic     release_now;

  pexc_fe_fold u_fold (
    .fe0(fe0), .fe1(fe1),
    .eff_fe0(eff_fe0), .eff_fe1(eff_fe1), .fe_off(fe_off)
  );

  pexc_decide #(.NFLAG(NFLAG)) u_decide (
    .is_illegal(is_illegal), .is_supv(is_supv), .is_emul(is_emul),
    .is_fp(is_fp), .is_trap(is_trap), .user_mode(user_mode),
    .trap_hit(trap_hit), .fe_off(fe_off),
    .fp_flags(fp_flags), .fp_enable(fp_enable), .fp_sticky(fp_sticky),
    .outcome(dec_outcome), .need_stall(need_stall)
  );

  assign accept = cmpl_valid & ~busy;

  pexc_serialize #(.STALL_CYC(STALL_CYC)) u_ser (
    .clk(clk), .rst_n(rst_n), .accept(accept), .need_stall(need_stall),
    .busy(busy), .release_now(release_now)
  );

  // result registers
  outcome_e out_q;
  logic     fp_q;
  outcome_e pend_q;
  logic     pend_fp_q;
  logic     done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= OUT_NORMAL;
      fp_q      <= 1'b0;
      pend_q    <= OUT_NORMAL;
      pend_fp_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept && need_stall) begin
        pend_q    <= dec_outcome;
        pend_fp_q <= is_fp;
      end else if (accept) begin
        out_q  <= dec_outcome;
        fp_q   <= is_fp;
        done_q <= 1'b1;
      end else if (release_now) begin
        out_q  <= pend_q;
        fp_q   <= pend_fp_q;
        done_q <= 1'b1;
      end
    end
  end

  function automatic logic [VEC_W-1:0] vector_of(input outcome_e o);
    if (uses_prog_vec(o))     return PROG_VEC;
    else if (uses_emu_vec(o)) return EMU_VEC;
    else                      return '0;
  endfunction

  logic normal_q;
  assign normal_q   = (out_q == OUT_NORMAL);
  assign done_valid = done_q;
  assign exc_taken  = done_q & ~normal_q;
  assign vector     = done_q ? vector_of(out_q) : '0;
  assign cause      = done_q ? cause_of(out_q) : '0;
  assign fpscr_we   = done_q & normal_q & fp_q;
  assign fpr_we     = done_q & normal_q & fp_q;

  // assertions
  a_r1_prog_vec: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && cause[C_ILLEGAL] |-> vector == PROG_VEC && !fpscr_we && !fpr_we);

  a_r4_emu_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && vector == EMU_VEC |-> !fpscr_we && !fpr_we && exc_taken);

  a_r9_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));

  a_r9_clean_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |-> vector == '0 && cause == '0);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_valid);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !busy && !cmpl_valid |=> !done_valid);

  a_r5_no_stall_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (fe0 != fe1) |=> !busy);
endmodule

// File: tb/test_prog_exc_classifier.sv
module test_prog_exc_classifier;
  localparam int CLK_P = 10;
  localparam int NF    = 5;
  localparam logic [31:0] PV = 32'h700;
  localparam logic [31:0] EV = 32'h1600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmpl_valid = 0, is_illegal = 0, is_supv = 0, is_emul = 0, is_fp = 0, is_trap = 0;
  logic user_mode = 0, trap_hit = 0, fe0 = 0, fe1 = 0;
  logic [NF-1:0] fp_flags = '0, fp_enable = '0, fp_sticky = '0;
  logic busy, done_valid, exc_taken, fpscr_we, fpr_we;
  logic [31:0] vector;
  logic [3:0] cause;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  prog_exc_classifier i_prog_exc_classifier (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid),
    .is_illegal(is_illegal), .is_supv(is_supv), .is_emul(is_emul),
    .is_fp(is_fp), .is_trap(is_trap), .user_mode(user_mode),
    .trap_hit(trap_hit), .fe0(fe0), .fe1(fe1),
    .fp_flags(fp_flags), .fp_enable(fp_enable), .fp_sticky(fp_sticky),
    .busy(busy), .done_valid(done_valid), .exc_taken(exc_taken),
    .vector(vector), .cause(cause), .fpscr_we(fpscr_we), .fpr_we(fpr_we)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outcome restated from the requirements
  logic [31:0] e_vec; logic [3:0] e_cause; logic e_we; int e_stall;
  task automatic model();
    e_vec = 0; e_cause = 0; e_we = 0; e_stall = 0;
    if (is_illegal) begin e_vec = PV; e_cause = 4'b0001; end
    else if (is_supv && user_mode) begin e_vec = PV; e_cause = 4'b0010; end
    else if (is_emul) e_vec = EV;
    else if (is_fp && (fp_flags & fp_enable) != 0) begin e_vec = EV; e_cause = 4'b1000; end
    else if (is_trap && trap_hit) begin e_vec = PV; e_cause = 4'b0100; end
    else begin
      e_we = is_fp;
      if (is_fp && !fe0 && !fe1 && (fp_flags & ~fp_sticky) != 0) e_stall = 2;
    end
  endtask

  task automatic clear_in();
    {is_illegal, is_supv, is_emul, is_fp, is_trap, user_mode, trap_hit, fe0, fe1} = '0;
    fp_flags = '0; fp_enable = '0; fp_sticky = '0;
  endtask

  // issue the currently driven instruction and check its completion
  task automatic run_case(input string tag);
    int n;
    model();
    @(negedge clk); cmpl_valid = 1;
    @(negedge clk); cmpl_valid = 0;
    n = 0;
    while (!done_valid && n < 8) begin
      check(busy === 1'b1, {tag, " busy during stall"}, 32'(busy), 1);
      @(negedge clk); n++;
    end
    check(n == e_stall, {tag, " stall cycles"}, n, e_stall);
    check(done_valid === 1'b1, {tag, " done"}, 32'(done_valid), 1);
    check(vector === e_vec, {tag, " vector"}, vector, e_vec);
    check(cause === e_cause, {tag, " cause"}, 32'(cause), 32'(e_cause));
    check(exc_taken === (e_vec != 0), {tag, " exc_taken"}, 32'(exc_taken), 32'(e_vec != 0));
    check(fpscr_we === e_we && fpr_we === e_we, {tag, " write enables"},
          {fpscr_we, fpr_we}, {e_we, e_we});
    @(negedge clk);
    check(done_valid === 1'b0, {tag, " single pulse"}, 32'(done_valid), 0);
    clear_in();
  endtask

  task automatic t_reset();
    check(done_valid === 0 && busy === 0 && exc_taken === 0 && vector === 0 &&
          cause === 0 && fpscr_we === 0 && fpr_we === 0, "R11 reset outputs",
          {done_valid, busy, exc_taken, fpscr_we, fpr_we}, 0);
  endtask

  task automatic t_normal();
    run_case("R9 integer normal");
    is_fp = 1; run_case("R9 R7 fp no flags");
  endtask

  task automatic t_illegal();
    is_illegal = 1; is_supv = 1; user_mode = 1; is_emul = 1; is_trap = 1; trap_hit = 1;
    run_case("R1 illegal beats all");
  endtask

  task automatic t_priv();
    is_supv = 1; user_mode = 1; is_emul = 1; run_case("R2 privileged in user");
    is_supv = 1; user_mode = 0; run_case("R2 supervisor normal");
  endtask

  task automatic t_emul();
    is_emul = 1; is_fp = 1; fp_flags = 5'b00100; fp_enable = 5'b00100;
    is_trap = 1; trap_hit = 1;
    run_case("R3 emulated class");
  endtask

  task automatic t_fp_enabled();
    is_fp = 1; fp_flags = 5'b10010; fp_enable = 5'b00010; run_case("R4 enabled fe=00");
    is_fp = 1; fp_flags = 5'b00001; fp_enable = 5'b11111; fe0 = 1; fe1 = 1;
    is_trap = 1; trap_hit = 1;
    run_case("R4 enabled fe=11 beats trap");
  endtask

  task automatic t_sticky();
    is_fp = 1; fp_flags = 5'b01000; fp_sticky = 5'b00001; run_case("R6 new sticky stall");
    is_fp = 1; fp_flags = 5'b01000; fp_sticky = 5'b01001; run_case("R7 already sticky");
    is_fp = 1; fp_flags = 5'b01000; fe0 = 1; run_case("R5 fe=10 no stall");
    is_fp = 1; fp_flags = 5'b00010; fe1 = 1; run_case("R5 fe=01 no stall");
  endtask

  task automatic t_trap();
    is_trap = 1; trap_hit = 1; run_case("R8 trap taken");
    is_trap = 1; trap_hit = 0; run_case("R8 trap not met");
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    is_fp = 1; fp_flags = 5'b00001; cmpl_valid = 1;
    @(negedge clk);
    clear_in(); is_illegal = 1;
    check(busy === 1'b1, "R10 busy after stall accept", 32'(busy), 1);
    @(negedge clk); cmpl_valid = 0; clear_in();
    check(done_valid === 1'b0, "R10 no early completion", 32'(done_valid), 0);
    @(negedge clk);
    check(done_valid === 1'b1 && cause === 0 && fpr_we === 1, "R10 stalled result intact",
          {done_valid, cause, fpr_we}, 32'b1_0000_1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(done_valid === 1'b0, "R10 ignored request dropped", 32'(done_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_illegal();
    t_priv();
    t_emul();
    t_fp_enabled();
    t_sticky();
    t_trap();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule